// File: doc/BRIEF.md
# Synchronizer Mode Control FSM

This block is the control state machine of a network timing synchronizer. It runs on the 8 kHz frame clock. It takes a two-bit mode request, a reference request and a phase-continuity request. From these it drives three outputs: the operating mode for the digital PLL, the choice between the primary and secondary reference for the input multiplexer, and a one-frame enable for the time-interval-error corrector.

The request inputs can come from pins or from register bits. They pass through a synchronizer chain before they are decoded, so a request takes effect on the third frame-clock edge after it is applied. The reserved mode code does not disturb the machine: it keeps its current state and latches an error flag. A two-bit state output and a one-frame change strobe let the surrounding logic follow every transition.

Top module: `tsync_mode_ctrl`

## Requirements
- R1: `mode_o` follows `mode_req_i` on the third rising edge of `clk_frame` after the request is applied. The encoding is 00 = Normal, 01 = Holdover, 10 = Freerun.
- R2: `ref_sec_o` follows `ref_req_i` with the same three-edge latency. The value 0 selects the primary reference and 1 selects the secondary reference.
- R3: When the decoded mode request is the reserved code 11, `mode_o` and `ref_sec_o` keep their previous values and `state_chg_o` stays low.
- R4: `rsvd_err_o` rises on the first edge at which the reserved code is decoded. It then stays high until reset.
- R5: A change from Holdover on the primary reference to Normal on the primary reference raises `tie_en_o` for exactly one frame, provided the decoded continuity request (`cont_req_i`, same three-edge latency) is 1. The pulse is high in the same frame as the new state.
- R6: `tie_en_o` stays low in every other case. This includes the same change made with continuity 0, Holdover-to-Normal on the secondary reference, and a Holdover-to-Normal change that also switches the reference.
- R7: `state_chg_o` is high for exactly the frame in which `mode_o` or `ref_sec_o` differs from the frame before, and low otherwise.
- R8: While `rst_n` is low the outputs are Freerun (10), primary, `tie_en_o` low, `state_chg_o` low and `rsvd_err_o` low. `rst_n` asserts asynchronously and releases on the frame clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_frame | input | 1 | 8 kHz frame clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req_i | input | 2 | Requested mode: 00 Normal, 01 Holdover, 10 Freerun, 11 reserved |
| ref_req_i | input | 1 | Requested reference: 0 primary, 1 secondary |
| cont_req_i | input | 1 | Phase-continuity request for the Holdover-to-Normal change |
| mode_o | output | 2 | Current operating mode sent to the PLL |
| ref_sec_o | output | 1 | Active reference sent to the input multiplexer |
| tie_en_o | output | 1 | One-frame enable pulse for the TIE corrector |
| state_chg_o | output | 1 | One-frame strobe on any mode or reference change |
| rsvd_err_o | output | 1 | Sticky flag: reserved mode code was decoded |

## Verification
The bench steers the requests into primary Holdover-to-Normal changes. It runs them with continuity set and clear, on the secondary reference, and with a reference switch made in the same frame. A design that checked only the new state, or only the mode, would pulse the corrector on the wrong edges. The bench inserts reserved codes between legal requests. A machine that decoded 11 as a mode, or cleared the error flag on the next legal code, would show a changed mode or a dropped flag. The bench also tracks the exact three-edge latency, so a missing or extra synchronizer stage shows up as outputs one frame early or late.

// File: rtl/tsync_pkg.sv
package tsync_pkg;
  localparam logic [1:0] MD_NORMAL   = 2'b00;
  localparam logic [1:0] MD_HOLDOVER = 2'b01;
  localparam logic [1:0] MD_FREERUN  = 2'b10;
  localparam logic [1:0] MD_RSVD     = 2'b11;

  typedef struct packed {
    logic [1:0] mode;
    logic       ref_sec;
    logic       cont;
  } req_t;

  localparam int REQ_W = $bits(req_t);
  localparam req_t REQ_RST = '{mode: MD_FREERUN, ref_sec: 1'b0, cont: 1'b0};
endpackage

// File: rtl/tsync_rst_sync.sv
module tsync_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/tsync_req_sync.sv
module tsync_req_sync #(
  parameter int STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  tsync_pkg::req_t    req_i,
  output tsync_pkg::req_t    req_o
);
  import tsync_pkg::*;

  req_t stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= REQ_RST;
    else        stage_q[0] <= req_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= REQ_RST;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign req_o = stage_q[STAGES-1];
endmodule

// File: rtl/tsync_mode_core.sv
module tsync_mode_core (
  input  logic             clk,
  input  logic             rst_n,
  input  tsync_pkg::req_t  req_i,
  output logic [1:0]       mode_o,
  output logic             ref_sec_o,
  output logic             tie_en_o,
  output logic             chg_o,
  output logic             err_o
);
  import tsync_pkg::*;

  logic [1:0] mode_q, mode_d;
  logic       ref_q, ref_d;
  logic       tie_q, tie_d;
  logic       chg_q, chg_d;
  logic       err_q, err_d;
  logic       upd_en;
  logic       leave_hold_pri;

  assign upd_en         = (req_i.mode != MD_RSVD);
  assign leave_hold_pri = (mode_q == MD_HOLDOVER) && !ref_q;

  always_comb begin
    mode_d = mode_q;
    ref_d  = ref_q;
    tie_d  = 1'b0;
    chg_d  = 1'b0;
    err_d  = err_q | !upd_en;
    if (upd_en) begin
      mode_d = req_i.mode;
      ref_d  = req_i.ref_sec;
      chg_d  = (mode_d != mode_q) || (ref_d != ref_q);
      tie_d  = leave_hold_pri && (mode_d == MD_NORMAL) && !ref_d && req_i.cont;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_FREERUN;
      ref_q  <= 1'b0;
    end else if (upd_en) begin
      mode_q <= mode_d;
      ref_q  <= ref_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tie_q <= 1'b0;
      chg_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      tie_q <= tie_d;
      chg_q <= chg_d;
      err_q <= err_d;
    end
  end

  assign mode_o    = mode_q;
  assign ref_sec_o = ref_q;
  assign tie_en_o  = tie_q;
  assign chg_o     = chg_q;
  assign err_o     = err_q;

  p_legal_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != MD_RSVD);

  p_hold_on_rsvd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i.mode == MD_RSVD) |=> (mode_q == $past(mode_q)) && (ref_q == $past(ref_q)) && !chg_q);

  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  p_tie_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tie_q |=> !tie_q);

  p_tie_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tie_q |-> (mode_q == MD_NORMAL) && !ref_q && chg_q);

  p_chg_real_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q |-> (mode_q != $past(mode_q)) || (ref_q != $past(ref_q)));
endmodule

// File: rtl/tsync_mode_ctrl.sv
module tsync_mode_ctrl #(
  parameter int RST_STAGES = 2,
  parameter int REQ_STAGES = 2
) (
  input  logic       clk_frame,
  input  logic       rst_n,
  input  logic [1:0] mode_req_i,
  input  logic       ref_req_i,
  input  logic       cont_req_i,
  output logic [1:0] mode_o,
  output logic       ref_sec_o,
  output logic       tie_en_o,
  output logic       state_chg_o,
  output logic       rsvd_err_o
);
  import tsync_pkg::*;

  logic rst_n_int;
  req_t req_raw, req_sync;

  assign req_raw = '{mode: mode_req_i, ref_sec: ref_req_i, cont: cont_req_i};

  tsync_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk_frame),
    .arst_n     (rst_n),
    .rst_n_sync (rst_n_int)
  );

  tsync_req_sync #(.STAGES(REQ_STAGES)) u_req (
    .clk   (clk_frame),
    .rst_n (rst_n_int),
    .req_i (req_raw),
    .req_o (req_sync)
  );

  tsync_mode_core u_core (
    .clk       (clk_frame),
    .rst_n     (rst_n_int),
    .req_i     (req_sync),
    .mode_o    (mode_o),
    .ref_sec_o (ref_sec_o),
    .tie_en_o  (tie_en_o),
    .chg_o     (state_chg_o),
    .err_o     (rsvd_err_o)
  );

  p_reset_state_r8: assert property (@(posedge clk_frame)
    !rst_n |-> (mode_o == MD_FREERUN) && !ref_sec_o && !tie_en_o && !state_chg_o && !rsvd_err_o);
endmodule

// File: tb/tsync_mode_ctrl_test.sv
module tsync_mode_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode_req;
  logic       ref_req, cont_req;
  logic [1:0] mode_o;
  logic       ref_sec_o, tie_en_o, state_chg_o, rsvd_err_o;

  int checks = 0;
  int errors = 0;
  int tie_pulses = 0;

  logic [1:0] m_mode;
  logic       m_ref, m_tie, m_chg, m_err;
  logic [3:0] p1, p2;

  always #4ns clk = ~clk;

  tsync_mode_ctrl uut (
    .clk_frame   (clk),
    .rst_n       (rst_n),
    .mode_req_i  (mode_req),
    .ref_req_i   (ref_req),
    .cont_req_i  (cont_req),
    .mode_o      (mode_o),
    .ref_sec_o   (ref_sec_o),
    .tie_en_o    (tie_en_o),
    .state_chg_o (state_chg_o),
    .rsvd_err_o  (rsvd_err_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic tie_expect(input logic [1:0] om, input logic orf,
                                      input logic [1:0] nm, input logic nrf, input logic c);
    return (om == 2'b01) && !orf && (nm == 2'b00) && !nrf && c;
  endfunction

  task automatic model_step();
    if (p2[3:2] == 2'b11) begin
      m_err = 1'b1;
      m_chg = 1'b0;
      m_tie = 1'b0;
    end else begin
      m_tie  = tie_expect(m_mode, m_ref, p2[3:2], p2[1], p2[0]);
      m_chg  = (p2[3:2] != m_mode) || (p2[1] != m_ref);
      m_mode = p2[3:2];
      m_ref  = p2[1];
    end
    p2 = p1;
    p1 = {mode_req, ref_req, cont_req};
  endtask

  task automatic check_all();
    chk(mode_o == m_mode, "R1", "mode", mode_o, m_mode);
    chk(ref_sec_o == m_ref, "R2", "reference", ref_sec_o, m_ref);
    chk(state_chg_o == m_chg, "R7", "change strobe", state_chg_o, m_chg);
    chk(rsvd_err_o == m_err, "R4", "reserved flag", rsvd_err_o, m_err);
    chk(tie_en_o == m_tie, m_tie ? "R5" : "R6", "corrector enable", tie_en_o, m_tie);
    if (tie_en_o) tie_pulses++;
  endtask

  task automatic cycle(input logic [1:0] m, input logic r, input logic c);
    mode_req = m;
    ref_req  = r;
    cont_req = c;
    @(posedge clk);
    @(negedge clk);
    model_step();
    check_all();
  endtask

  task automatic hold(input int n, input logic [1:0] m, input logic r, input logic c);
    for (int i = 0; i < n; i++) cycle(m, r, c);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    mode_req = 2'b10; ref_req = 1'b0; cont_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(mode_o == 2'b10, "R8", "reset mode", mode_o, 2);
    chk(!ref_sec_o && !tie_en_o && !state_chg_o, "R8", "reset ref/tie/chg",
        {ref_sec_o, tie_en_o, state_chg_o}, 0);
    chk(!rsvd_err_o, "R8", "reset error flag", rsvd_err_o, 0);
    m_mode = 2'b10; m_ref = 1'b0; m_tie = 1'b0; m_chg = 1'b0; m_err = 1'b0;
    p1 = 4'b1000; p2 = 4'b1000;
    rst_n = 1'b1;
    hold(4, 2'b10, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int pulses_before;
    void'($urandom(32'd20240611));
    rst_n = 1'b1;
    mode_req = 2'b10; ref_req = 1'b0; cont_req = 1'b0;
    do_reset();

    // R1 latency: Holdover request appears on the third edge
    mode_req = 2'b01;
    @(posedge clk); @(negedge clk); model_step();
    chk(mode_o == 2'b10, "R1", "mode before latency", mode_o, 2);
    @(posedge clk); @(negedge clk); model_step();
    chk(mode_o == 2'b10, "R1", "mode before latency", mode_o, 2);
    @(posedge clk); @(negedge clk); model_step();
    chk(mode_o == 2'b01 && state_chg_o, "R1", "mode after three edges", mode_o, 1);
    hold(3, 2'b01, 1'b0, 1'b1);

    // R5: primary Holdover -> Normal with continuity set
    pulses_before = tie_pulses;
    hold(5, 2'b00, 1'b0, 1'b1);
    chk(tie_pulses == pulses_before + 1, "R5", "pulse count", tie_pulses - pulses_before, 1);

    // R6: same change, continuity clear
    hold(4, 2'b01, 1'b0, 1'b0);
    pulses_before = tie_pulses;
    hold(4, 2'b00, 1'b0, 1'b0);
    chk(tie_pulses == pulses_before, "R6", "no pulse, continuity 0", tie_pulses - pulses_before, 0);

    // R6: secondary Holdover -> secondary Normal
    hold(4, 2'b01, 1'b1, 1'b1);
    pulses_before = tie_pulses;
    hold(4, 2'b00, 1'b1, 1'b1);
    chk(tie_pulses == pulses_before, "R6", "no pulse, secondary", tie_pulses - pulses_before, 0);

    // R6: Holdover secondary -> Normal primary in one step
    hold(4, 2'b01, 1'b1, 1'b1);
    pulses_before = tie_pulses;
    hold(4, 2'b00, 1'b0, 1'b1);
    chk(tie_pulses == pulses_before, "R6", "no pulse, reference switch", tie_pulses - pulses_before, 0);

    // R3/R4: reserved code holds state and latches the flag
    hold(4, 2'b01, 1'b0, 1'b1);
    hold(4, 2'b11, 1'b1, 1'b1);
    chk(mode_o == 2'b01 && !ref_sec_o, "R3", "state held on reserved", {mode_o, ref_sec_o}, 2);
    chk(rsvd_err_o, "R4", "flag set", rsvd_err_o, 1);
    pulses_before = tie_pulses;
    hold(4, 2'b00, 1'b0, 1'b1);
    chk(rsvd_err_o, "R4", "flag kept after legal code", rsvd_err_o, 1);
    chk(tie_pulses == pulses_before + 1, "R5", "pulse after reserved gap", tie_pulses - pulses_before, 1);

    // R8: reset clears the sticky flag
    do_reset();
    chk(!rsvd_err_o, "R8", "flag cleared by reset", rsvd_err_o, 0);

    // Randomized requests, biased toward Holdover/Normal on primary
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] m;
      logic r, c;
      int sel;
      m = mode_req; r = ref_req; c = cont_req;
      if ($urandom % 2 == 0) begin
        sel = int'($urandom % 32);
        if (sel == 0)       m = 2'b11;
        else if (sel < 14)  m = 2'b00;
        else if (sel < 27)  m = 2'b01;
        else                m = 2'b10;
        r = ($urandom % 4 == 0);
        c = ($urandom % 3 != 0);
      end
      cycle(m, r, c);
    end
    chk(tie_pulses > 3, "R5", "random pulses observed", tie_pulses, 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule